// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core may issue an instruction. Each thread has its own program counter and register set elsewhere in the core, so changing threads costs nothing here beyond picking a new identifier. Per thread, the block takes three flags: ready, short stall and long stall. A thread is eligible when it is ready and has neither stall flag raised.

There are two scheduling policies, chosen by a configuration input. In fine-grain mode the selection rotates every cycle. The search starts at the thread after the last one that issued and skips any thread that is not eligible, so instructions from different threads interleave. In coarse-grain mode the current thread keeps issuing until it raises its long-stall flag, for example on a miss to the second-level cache. A short stall such as a data hazard does not move the selection away from the current thread; the block issues nothing for those cycles instead.

The outputs are the selected thread id, an issue-valid flag and a one-cycle switch indication. These are plain control pins with no handshake: the pipeline takes the selection in the same cycle and cannot push back on it.

Top module: `mt_issue_select`

## Requirements
- R1: After reset the current thread is 0 and fine-grain mode is active. With no thread eligible the outputs are sel_tid=0, issue_valid=0 and switch_pulse=0, and the first fine-grain grant searches from thread 1.
- R2: Thread i uses bit i of thr_ready, thr_short_stall and thr_long_stall, and it is eligible only when those bits are 1, 0 and 0. issue_valid=1 only when the thread on sel_tid is eligible.
- R3: In fine-grain mode (coarse_mode=0) the grant goes to the first eligible thread in the order cur+1, cur+2, and so on modulo the thread count. The current thread comes last in that order. Whenever two or more threads are eligible, the grant therefore moves to a different thread.
- R4: In fine-grain mode a thread that is stalled or not ready is passed over, and the next eligible thread in rotation order issues in its place.
- R5: In coarse-grain mode, while the current thread has thr_long_stall low, sel_tid stays on that thread. If the current thread is short-stalled or not ready, issue_valid=0 for that cycle even when other threads are eligible.
- R6: In coarse-grain mode, when the current thread raises thr_long_stall, the grant goes to the next eligible thread in rotation order after it. That thread then becomes current.
- R7: When no thread can be granted, issue_valid=0 and sel_tid repeats the previous cycle's value. The current thread does not change.
- R8: switch_pulse=1 exactly in the cycles where issue_valid=1 and sel_tid differs from the previous cycle's sel_tid.
- R9: A change on coarse_mode takes effect one cycle later. The policy used in a cycle is the one that coarse_mode held in the cycle before.
- R10: When only one thread is eligible in fine-grain mode, that thread issues on consecutive cycles, and switch_pulse stays 0 after the first grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 1 selects coarse-grain policy, 0 fine-grain (applied next cycle) |
| thr_ready | input | NUM_THREADS | Per-thread ready flag |
| thr_short_stall | input | NUM_THREADS | Per-thread short stall flag |
| thr_long_stall | input | NUM_THREADS | Per-thread long-latency stall flag |
| sel_tid | output | TID_W | Selected thread id |
| issue_valid | output | 1 | Selected thread issues this cycle |
| switch_pulse | output | 1 | Selection moved to a different thread this cycle |

## Verification
The hardest case to reach from the ports is a coarse-grain long stall at the moment the rotation pointer sits next to stalled or unready threads. In that cycle the grant has to wrap past several ineligible threads, and in one variant no other thread is eligible at all, so the block must bubble without moving. Directed steps first place the current thread through fine-grain grants and then switch the mode one cycle early. A long pseudo-random run that alternates the mode then covers the remaining combinations against a cycle model of the requirements.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } mt_mode_e;
endpackage

// File: rtl/mt_elig_vec.sv
module mt_elig_vec #(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0] rdy,
  input  logic [NUM_THREADS-1:0] sstall,
  input  logic [NUM_THREADS-1:0] lstall,
  output logic [NUM_THREADS-1:0] elig
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    assign elig[g] = rdy[g] & ~sstall[g] & ~lstall[g];
  end
endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0] req,
  input  logic [TID_W-1:0]       base,
  output logic                   hit,
  output logic [TID_W-1:0]       id
);
  // Scan from farthest offset to nearest; the nearest match wins.
  always_comb begin
    int t;
    hit = 1'b0;
    id  = base;
    for (int off = NUM_THREADS; off >= 1; off--) begin
      t = (int'(base) + off) % NUM_THREADS;
      if (req[t]) begin
        hit = 1'b1;
        id  = TID_W'(t);
      end
    end
  end
endmodule

// File: rtl/mt_sel_state.sv
module mt_sel_state
  import mt_sel_pkg::*;
#(
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_in,
  input  logic             adv,
  input  logic [TID_W-1:0] nxt_id,
  output logic [TID_W-1:0] cur_id,
  output mt_mode_e         mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_id <= '0;
      mode_q <= MODE_FINE;
    end else begin
      mode_q <= mt_mode_e'(mode_in);
      if (adv) cur_id <= nxt_id;
    end
  end
endmodule

// File: rtl/mt_issue_select.sv
module mt_issue_select
  import mt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   coarse_mode,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [NUM_THREADS-1:0] thr_short_stall,
  input  logic [NUM_THREADS-1:0] thr_long_stall,
  output logic [TID_W-1:0]       sel_tid,
  output logic                   issue_valid,
  output logic                   switch_pulse
);
  logic [NUM_THREADS-1:0] elig;
  logic                   pick_hit;
  logic [TID_W-1:0]       pick_id;
  logic [TID_W-1:0]       cur_id;
  mt_mode_e               mode_q;
  logic                   hold_cur;

  mt_elig_vec #(.NUM_THREADS(NUM_THREADS)) elig_i (
    .rdy    (thr_ready),
    .sstall (thr_short_stall),
    .lstall (thr_long_stall),
    .elig   (elig)
  );

  mt_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) pick_i (
    .req  (elig),
    .base (cur_id),
    .hit  (pick_hit),
    .id   (pick_id)
  );

  mt_sel_state #(.TID_W(TID_W)) state_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (coarse_mode),
    .adv     (issue_valid),
    .nxt_id  (sel_tid),
    .cur_id  (cur_id),
    .mode_q  (mode_q)
  );

  // Coarse mode stays on the current thread unless it hits a long stall.
  always_comb begin
    hold_cur = (mode_q == MODE_COARSE) && !thr_long_stall[cur_id];
    if (hold_cur) begin
      sel_tid     = cur_id;
      issue_valid = elig[cur_id];
    end else begin
      sel_tid     = pick_hit ? pick_id : cur_id;
      issue_valid = pick_hit;
    end
    switch_pulse = issue_valid && (sel_tid != cur_id);
  end
endmodule

// File: rtl/mt_issue_select_chk.sv
module mt_issue_select_chk #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   coarse_mode,
  input logic [NUM_THREADS-1:0] thr_ready,
  input logic [NUM_THREADS-1:0] thr_short_stall,
  input logic [NUM_THREADS-1:0] thr_long_stall,
  input logic [TID_W-1:0]       sel_tid,
  input logic                   issue_valid,
  input logic                   switch_pulse
);
  logic [TID_W-1:0] prev_sel;
  logic             prev_coarse;
  logic [NUM_THREADS-1:0] ok;
  assign ok = thr_ready & ~thr_short_stall & ~thr_long_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel    <= '0;
      prev_coarse <= 1'b0;
    end else begin
      prev_sel    <= sel_tid;
      prev_coarse <= coarse_mode;
    end
  end

  // R2
  valid_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (thr_ready[sel_tid] && !thr_short_stall[sel_tid] && !thr_long_stall[sel_tid]));

  // R7
  none_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok == '0) |-> !issue_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (sel_tid == prev_sel));

  // R8
  switch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse == (issue_valid && (sel_tid != prev_sel)));

  // R5
  coarse_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_coarse && !thr_long_stall[prev_sel]) |-> (sel_tid == prev_sel));

  // R3
  fine_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_coarse && ($countones(ok) >= 2)) |-> (issue_valid && sel_tid != prev_sel));
endmodule

bind mt_issue_select mt_issue_select_chk #(.NUM_THREADS(NUM_THREADS)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .coarse_mode     (coarse_mode),
  .thr_ready       (thr_ready),
  .thr_short_stall (thr_short_stall),
  .thr_long_stall  (thr_long_stall),
  .sel_tid         (sel_tid),
  .issue_valid     (issue_valid),
  .switch_pulse    (switch_pulse)
);

// File: tb/mt_issue_select_tb_top.sv
`timescale 1ns/1ps
module mt_issue_select_tb_top;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         coarse_mode = 1'b0;
  logic [N-1:0] thr_ready = '0;
  logic [N-1:0] thr_short_stall = '0;
  logic [N-1:0] thr_long_stall = '0;
  logic [W-1:0] sel_tid;
  logic         issue_valid;
  logic         switch_pulse;

  always #2 clk = ~clk;

  mt_issue_select #(.NUM_THREADS(N)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .coarse_mode     (coarse_mode),
    .thr_ready       (thr_ready),
    .thr_short_stall (thr_short_stall),
    .thr_long_stall  (thr_long_stall),
    .sel_tid         (sel_tid),
    .issue_valid     (issue_valid),
    .switch_pulse    (switch_pulse)
  );

  typedef struct {
    string        tag;
    logic         v;
    logic [W-1:0] s;
    logic         sw;
  } exp_t;

  exp_t   exp_q[$];
  int     n_checks = 0;
  int     n_fails  = 0;
  bit     done     = 0;
  logic [W-1:0] m_cur = '0;
  logic         m_coarse = 1'b0;

  // Reference model of the requirements; pushes the expected result.
  task automatic step(input logic mode, input logic [N-1:0] rdy,
                      input logic [N-1:0] sst, input logic [N-1:0] lst,
                      input string tag);
    exp_t e;
    logic [N-1:0] el;
    logic hit;
    logic [W-1:0] pid;
    @(negedge clk);
    coarse_mode     = mode;
    thr_ready       = rdy;
    thr_short_stall = sst;
    thr_long_stall  = lst;
    el  = rdy & ~sst & ~lst;
    hit = 1'b0;
    pid = m_cur;
    for (int off = N; off >= 1; off--) begin
      if (el[(int'(m_cur) + off) % N]) begin
        hit = 1'b1;
        pid = W'((int'(m_cur) + off) % N);
      end
    end
    e.tag = tag;
    if (m_coarse && !lst[m_cur]) begin
      e.s = m_cur;
      e.v = el[m_cur];
    end else begin
      e.s = pid;
      e.v = hit;
    end
    e.sw = e.v && (e.s != m_cur);
    exp_q.push_back(e);
    if (e.v) m_cur = e.s;
    m_coarse = mode;
  endtask

  // Monitor: samples one time unit after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (issue_valid !== e.v || sel_tid !== e.s || switch_pulse !== e.sw) begin
          n_fails++;
          $display("FAIL %s: act v=%0b tid=%0d sw=%0b exp v=%0b tid=%0d sw=%0b",
                   e.tag, issue_valid, sel_tid, switch_pulse, e.v, e.s, e.sw);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic        md;
    lf = 32'h1ACE_B00C;
    md = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, then first fine grant goes to thread 1
    step(0, 4'b0000, 4'b0000, 4'b0000, "R1");
    step(0, 4'b1111, 4'b0000, 4'b0000, "R1");
    // R3 rotation across all threads
    step(0, 4'b1111, 4'b0000, 4'b0000, "R3");
    step(0, 4'b1111, 4'b0000, 4'b0000, "R3");
    step(0, 4'b1111, 4'b0000, 4'b0000, "R3");
    step(0, 4'b1111, 4'b0000, 4'b0000, "R3");
    // R4 skipping short-stalled, long-stalled and unready threads
    step(0, 4'b1111, 4'b0100, 4'b0000, "R4");
    step(0, 4'b1111, 4'b0000, 4'b0001, "R4");
    step(0, 4'b1011, 4'b0000, 4'b0010, "R4");
    // R7 nothing eligible: hold
    step(0, 4'b0000, 4'b0000, 4'b0000, "R7");
    step(0, 4'b1111, 4'b1111, 4'b0000, "R7");
    // R10 single eligible thread
    step(0, 4'b0100, 4'b0000, 4'b0000, "R10");
    step(0, 4'b0100, 4'b0000, 4'b0000, "R10");
    step(0, 4'b0100, 4'b0000, 4'b0000, "R10");
    // R9 mode raised this cycle, still fine-grain behaviour now
    step(1, 4'b1111, 4'b0000, 4'b0000, "R9");
    // R5 coarse: stays; short stall and not-ready bubble
    step(1, 4'b1111, 4'b0000, 4'b0000, "R5");
    step(1, 4'b1111, 4'b0000, 4'b0000, "R5");
    step(1, 4'b1111, 4'b1111, 4'b0000, "R5");
    step(1, 4'b0000, 4'b0000, 4'b0000, "R5");
    step(1, 4'b1111, 4'b0000, 4'b0000, "R5");
    // R6 long stall on current forces switch with wrap past stalled threads
    step(1, 4'b1111, 4'b0000, 4'b1111, "R6");
    step(1, 4'b1111, 4'b0000, 4'b0000, "R6");
    step(1, 4'b1011, 4'b0001, 4'b1000, "R6");
    step(1, 4'b1111, 4'b0000, 4'b0000, "R6");
    step(1, 4'b1111, 4'b0000, 4'b0000, "R8");
    // R9 drop back to fine-grain
    step(0, 4'b1111, 4'b0000, 4'b0000, "R9");
    step(0, 4'b1111, 4'b0000, 4'b0000, "R9");
    // R2 pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (i % 17 == 0) md = ~md;
      step(md, lf[3:0] | lf[7:4], lf[11:8] & lf[15:12],
           lf[19:16] & lf[23:20] & lf[27:24], "R2");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule